// File: doc/BRIEF.md
# Set-Associative Read Cache with Shared Round-Robin Victim Counter

This block sits between a processor's read port and a slower memory. It holds 128 sets of four ways, and each way holds a 16-byte line. Reads arrive through a valid/ready handshake and return one 32-bit word. A hit answers on the next cycle. A miss fetches the whole line from memory as four word beats, installs it, and then answers.

Placement on a miss works as follows. If the set has an empty way, the lowest-numbered empty way takes the line. If the set is full, the victim way comes from one 2-bit counter that every set shares. That counter moves forward only when a valid line is actually evicted. Hits and fills into empty ways leave it alone. Because of this, lines can remain resident long after they stop being useful, and the counter value after a long access pattern follows a simple rule.

A flush input, like reset, invalidates every line and returns the counter to zero. The counter value is brought out on a port so its global behaviour can be observed.

Top module: `shared_victim_cache`

## Requirements
- R1: A read address splits into word select (bits 3:2), set index (bits 10:4) and tag (bits 31:11), so 16-byte block i lands in set i mod 128. At most one way of a set matches a lookup.
- R2: A read that hits is answered on the cycle right after it is accepted, with `rsp_hit_o`=1 and the addressed word.
- R3: A read that misses raises `fill_req_o` for one cycle with the line-aligned address (bits 3:0 zero). It takes four beats on `fill_valid_i` carrying words 0,1,2,3 of the line. It answers on the cycle after the fourth beat with `rsp_hit_o`=0 and the addressed word.
- R4: A hit never changes `rr_count_o`.
- R5: A miss into a set that still has an empty way fills the lowest-numbered empty way and leaves `rr_count_o` unchanged.
- R6: A miss into a full set replaces the way numbered by `rr_count_o`. The counter then advances by one modulo 4 when the final beat arrives.
- R7: A single counter serves every set. After blocks 0..511 are read in order from empty, it reads 0. After block 512 it reads 1. After block 639 it reads 0 again.
- R8: Only one read is in progress at a time: `req_ready_o` is low from the accepted miss until its final beat.
- R9: Reset or a one-cycle `flush_i` invalidates all lines and sets `rr_count_o` to 0. While `flush_i` is high, `req_ready_o` is low, so a read presented in that cycle is not accepted.
- R10: A flush during a refill (including the cycle of the final beat) still lets that read complete with the fetched word. The line is not installed and the counter is not advanced, so the same address misses again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all lines and clear the victim counter |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Cache can accept a read |
| req_addr_i | input | 32 | Byte address of the read |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_hit_o | output | 1 | Response was served from a resident line |
| rsp_data_o | output | 32 | Read word |
| fill_req_o | output | 1 | Line fetch request (one cycle) |
| fill_addr_o | output | 32 | Line-aligned fetch address |
| fill_valid_i | input | 1 | Fetch beat valid |
| fill_data_i | input | 32 | Fetch beat word |
| rr_count_o | output | 2 | Shared victim counter value |

## Verification
The interesting collision is a flush landing on a refill, and above all on the very cycle of the fourth beat. In that cycle the counter would otherwise advance and the line would become valid. The memory model in the bench raises the flush on a chosen beat index, once mid-line and once on the last beat into a full set. The bench then judges three things: the response still carries the fetched word, the counter reads 0, and a repeat of the same address misses. A flush raised together with a pending read is also checked, by observing that `req_ready_o` is low in that cycle.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2
    } fsm_e;

endpackage

// File: rtl/way_match.sv
module way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 21,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       valid_i,
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]      tag_i,
    output logic [WAYS-1:0]       hit_vec_o,
    output logic                  hit_o,
    output logic [WAY_W-1:0]      hit_way_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
    end

    always_comb begin
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
        end
    end

    assign hit_o = |hit_vec_o;

endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] ctr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             evict_o
);

    // Lowest empty way wins; only a full set falls back to the shared counter.
    always_comb begin
        way_o   = ctr_i;
        evict_o = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                way_o   = WAY_W'(w);
                evict_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/shared_victim_cache.sv
module shared_victim_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [WORD_W-1:0] rsp_data_o,
    output logic              fill_req_o,
    output logic [ADDR_W-1:0] fill_addr_o,
    input  logic              fill_valid_i,
    input  logic [WORD_W-1:0] fill_data_i,
    output logic [$clog2(WAYS)-1:0] rr_count_o
);

    localparam int WPL    = LINE_BYTES / (WORD_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WSEL_W = $clog2(WPL);
    localparam int BSEL_W = OFF_W - WSEL_W;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    typedef struct packed {
        fsm_e              st;
        logic [SET_W-1:0]  set;
        logic [TAG_W-1:0]  tag;
        logic [WSEL_W-1:0] word;
        logic [WAY_W-1:0]  way;
        logic              evict;
        logic [WSEL_W-1:0] beat;
        logic              kill;
        logic [WAY_W-1:0]  ctr;
        logic              rsp_v;
        logic              rsp_hit;
        logic [WORD_W-1:0] rsp_d;
    } state_t;

    state_t state_q, state_d;

    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WORD_W-1:0] data_q  [SETS][WAYS][WPL];

    logic [SET_W-1:0]      lk_set;
    logic [TAG_W-1:0]      lk_tag;
    logic [WSEL_W-1:0]     lk_word;
    logic [WAYS*TAG_W-1:0] lk_tags;
    logic [WAYS-1:0]       hit_vec;
    logic                  lk_hit;
    logic [WAY_W-1:0]      hit_way;
    logic [WAY_W-1:0]      vic_way;
    logic                  vic_evict;
    logic                  accept;
    logic                  data_we;
    logic                  line_we;
    logic                  addr_unused;

    assign lk_set      = req_addr_i[OFF_W +: SET_W];
    assign lk_tag      = req_addr_i[ADDR_W-1 -: TAG_W];
    assign lk_word     = req_addr_i[BSEL_W +: WSEL_W];
    assign addr_unused = ^req_addr_i[BSEL_W-1:0];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_tags[w*TAG_W +: TAG_W] = tag_q[lk_set][w];
        end
    end

    way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .valid_i   (valid_q[lk_set]),
        .tags_i    (lk_tags),
        .tag_i     (lk_tag),
        .hit_vec_o (hit_vec),
        .hit_o     (lk_hit),
        .hit_way_o (hit_way)
    );

    victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_i (valid_q[lk_set]),
        .ctr_i   (state_q.ctr),
        .way_o   (vic_way),
        .evict_o (vic_evict)
    );

    assign req_ready_o = (state_q.st == ST_IDLE) && !flush_i;
    assign accept      = req_valid_i && req_ready_o;

    always_comb begin
        state_d       = state_q;
        state_d.rsp_v = 1'b0;
        data_we       = 1'b0;
        line_we       = 1'b0;
        case (state_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (lk_hit) begin
                        state_d.rsp_v   = 1'b1;
                        state_d.rsp_hit = 1'b1;
                        state_d.rsp_d   = data_q[lk_set][hit_way][lk_word];
                    end else begin
                        state_d.st    = ST_REQ;
                        state_d.set   = lk_set;
                        state_d.tag   = lk_tag;
                        state_d.word  = lk_word;
                        state_d.way   = vic_way;
                        state_d.evict = vic_evict;
                        state_d.beat  = '0;
                        state_d.kill  = 1'b0;
                    end
                end
            end
            ST_REQ: begin
                state_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (fill_valid_i) begin
                    data_we      = 1'b1;
                    state_d.beat = state_q.beat + 1'b1;
                    if (state_q.beat == state_q.word) state_d.rsp_d = fill_data_i;
                    if (state_q.beat == WSEL_W'(WPL - 1)) begin
                        state_d.st      = ST_IDLE;
                        state_d.rsp_v   = 1'b1;
                        state_d.rsp_hit = 1'b0;
                        if (!state_q.kill && !flush_i) begin
                            line_we = 1'b1;
                            if (state_q.evict) state_d.ctr = state_q.ctr + 1'b1;
                        end
                    end
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
        if (flush_i) begin
            state_d.ctr = '0;
            if (state_q.st != ST_IDLE) state_d.kill = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (flush_i) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (line_we) begin
            valid_q[state_q.set][state_q.way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (line_we) tag_q[state_q.set][state_q.way] <= state_q.tag;
        if (data_we) data_q[state_q.set][state_q.way][state_q.beat] <= fill_data_i;
    end

    assign rsp_valid_o = state_q.rsp_v;
    assign rsp_hit_o   = state_q.rsp_hit;
    assign rsp_data_o  = state_q.rsp_d;
    assign fill_req_o  = (state_q.st == ST_REQ);
    assign fill_addr_o = {state_q.tag, state_q.set, OFF_W'(0)};
    assign rr_count_o  = state_q.ctr;

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              rsp_valid_o,
    input logic              rsp_hit_o,
    input logic              fill_req_o,
    input logic [ADDR_W-1:0] fill_addr_o,
    input logic              fill_valid_i,
    input logic [WAY_W-1:0]  rr_count_o,
    input logic [WAYS-1:0]   hit_vec,
    input logic              lk_hit
);

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R1

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && lk_hit) |=> (rsp_valid_o && rsp_hit_o)); // R2

    AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o |-> (fill_addr_o[OFF_W-1:0] == '0)); // R3

    AST_CTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_valid_i && !flush_i) |=> $stable(rr_count_o)); // R4

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rr_count_o) |-> ((rr_count_o == WAY_W'($past(rr_count_o) + 1'b1)) || (rr_count_o == '0))); // R6

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o |-> !req_ready_o); // R8

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !req_ready_o); // R9

endmodule

bind shared_victim_cache cache_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .WAYS   (WAYS),
    .WAY_W  (WAY_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_hit_o    (rsp_hit_o),
    .fill_req_o   (fill_req_o),
    .fill_addr_o  (fill_addr_o),
    .fill_valid_i (fill_valid_i),
    .rr_count_o   (rr_count_o),
    .hit_vec      (hit_vec),
    .lk_hit       (lk_hit)
);

// File: tb/shared_victim_cache_bench.sv
`timescale 1ns/1ps
module shared_victim_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_flush = 1'b0;
    logic        mem_flush;
    logic        flush_i;
    logic        req_valid = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_addr = '0;
    logic        rsp_valid_o;
    logic        rsp_hit_o;
    logic [31:0] rsp_data_o;
    logic        fill_req_o;
    logic [31:0] fill_addr_o;
    logic        fill_valid;
    logic [31:0] fill_data;
    logic [1:0]  rr_count_o;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] cur_addr = '0;
    int          flush_beat = -1;
    logic [31:0] exp_data[$];
    bit          exp_hit[$];

    assign flush_i = tb_flush | mem_flush;

    always #2.5 clk = ~clk;

    shared_victim_cache u_shared_victim_cache (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready_o),
        .req_addr_i   (req_addr),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_hit_o    (rsp_hit_o),
        .rsp_data_o   (rsp_data_o),
        .fill_req_o   (fill_req_o),
        .fill_addr_o  (fill_addr_o),
        .fill_valid_i (fill_valid),
        .fill_data_i  (fill_data),
        .rr_count_o   (rr_count_o)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A3C_0F00;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    // Driver: pushes the expected response, then issues the read.
    task automatic rd(input logic [31:0] a, input bit hit);
        cur_addr = a;
        exp_data.push_back(mem_word(a));
        exp_hit.push_back(hit);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) chk(rsp_valid_o == 1'b1, "R2 hit latency", 32'(rsp_valid_o), 32'd1);
        while (exp_data.size() != 0) @(negedge clk);
    endtask

    function automatic logic [31:0] blk(input int b, input int w);
        return 32'(b * 16 + w * 4);
    endfunction

    // Monitor: compares every response against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid_o) begin
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R8 unexpected response", rsp_data_o, 32'hX);
                end else begin
                    logic [31:0] ed;
                    bit          eh;
                    ed = exp_data.pop_front();
                    eh = exp_hit.pop_front();
                    chk(rsp_data_o == ed, eh ? "R2 hit data" : "R3 miss data", rsp_data_o, ed);
                    chk(rsp_hit_o == eh, eh ? "R2 hit flag" : "R3 miss flag", 32'(rsp_hit_o), 32'(eh));
                end
            end
        end
    end

    // Memory model: answers a fill request with four beats, optional flush on one beat.
    initial begin
        fill_valid = 1'b0;
        fill_data  = '0;
        mem_flush  = 1'b0;
        forever begin
            @(negedge clk);
            if (fill_req_o) begin
                logic [31:0] la;
                la = fill_addr_o;
                chk(la == {cur_addr[31:4], 4'b0}, "R3 fill address", la, {cur_addr[31:4], 4'b0});
                repeat (2) @(negedge clk);
                for (int b = 0; b < 4; b++) begin
                    fill_valid = 1'b1;
                    fill_data  = mem_word(la + 32'(b * 4));
                    mem_flush  = (b == flush_beat);
                    @(negedge clk);
                end
                fill_valid = 1'b0;
                mem_flush  = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R8 actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(req_ready_o == 1'b1, "R9 reset ready", 32'(req_ready_o), 32'd1);
        chk(rr_count_o == 2'd0, "R9 reset counter", 32'(rr_count_o), 32'd0);
        chk(rsp_valid_o == 1'b0, "R9 reset rsp", 32'(rsp_valid_o), 32'd0);
        chk(fill_req_o == 1'b0, "R9 reset fill", 32'(fill_req_o), 32'd0);

        // R1/R7: sequential blocks 0..639 from empty
        for (int i = 0; i < 640; i++) begin
            rd(blk(i, i % 4), 1'b0);
            if (i == 255) chk(rr_count_o == 2'd0, "R5 allocs leave counter", 32'(rr_count_o), 32'd0);
            if (i == 511) chk(rr_count_o == 2'd0, "R7 counter after 511", 32'(rr_count_o), 32'd0);
            if (i == 512) begin
                chk(rr_count_o == 2'd1, "R6 counter after 512", 32'(rr_count_o), 32'd1);
                rd(blk(1, 2), 1'b1); // R7: block 1 still resident
                chk(rr_count_o == 2'd1, "R4 hit keeps counter", 32'(rr_count_o), 32'd1);
            end
        end
        chk(rr_count_o == 2'd0, "R7 counter after 639", 32'(rr_count_o), 32'd0);
        rd(blk(639, 3), 1'b1);
        rd(blk(385, 0), 1'b1); // R1: set 1, way 3, untouched by 513
        chk(rr_count_o == 2'd0, "R4 counter after hits", 32'(rr_count_o), 32'd0);

        // R9: flush together with a pending read
        @(negedge clk);
        tb_flush  = 1'b1;
        req_valid = 1'b1;
        req_addr  = blk(639, 0);
        #1;
        chk(req_ready_o == 1'b0, "R9 flush blocks accept", 32'(req_ready_o), 32'd0);
        @(negedge clk);
        tb_flush  = 1'b0;
        req_valid = 1'b0;
        chk(rr_count_o == 2'd0, "R9 flush clears counter", 32'(rr_count_o), 32'd0);
        rd(blk(639, 0), 1'b0);

        // R5/R6: set 5 filled from empty, then evictions
        rd(blk(5, 0), 1'b0);
        rd(blk(133, 1), 1'b0);
        rd(blk(261, 2), 1'b0);
        rd(blk(389, 3), 1'b0);
        chk(rr_count_o == 2'd0, "R5 counter after set fill", 32'(rr_count_o), 32'd0);
        rd(blk(517, 0), 1'b0);
        chk(rr_count_o == 2'd1, "R6 counter after evict", 32'(rr_count_o), 32'd1);
        rd(blk(133, 0), 1'b1); // R5: second block sat in way 1
        rd(blk(5, 1), 1'b0);   // R5: first block sat in way 0 and was evicted
        chk(rr_count_o == 2'd2, "R6 counter second evict", 32'(rr_count_o), 32'd2);
        rd(blk(261, 3), 1'b1);
        rd(blk(133, 2), 1'b0); // R6: way 1 was the victim

        // R10: flush mid-refill
        flush_beat = 1;
        rd(blk(645, 2), 1'b0);
        flush_beat = -1;
        chk(rr_count_o == 2'd0, "R10 counter after mid flush", 32'(rr_count_o), 32'd0);
        rd(blk(645, 2), 1'b0);
        rd(blk(645, 1), 1'b1);

        // R10: flush on the final beat of an evicting refill
        rd(blk(9, 0), 1'b0);
        rd(blk(137, 0), 1'b0);
        rd(blk(265, 0), 1'b0);
        rd(blk(393, 0), 1'b0);
        chk(rr_count_o == 2'd0, "R5 counter set 9 full", 32'(rr_count_o), 32'd0);
        flush_beat = 3;
        rd(blk(521, 3), 1'b0);
        flush_beat = -1;
        chk(rr_count_o == 2'd0, "R10 counter after last-beat flush", 32'(rr_count_o), 32'd0);
        rd(blk(521, 3), 1'b0);
        rd(blk(9, 0), 1'b0);
        chk(rr_count_o == 2'd0, "R10 refills after flush allocate", 32'(rr_count_o), 32'd0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule